// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block chooses one exception to enter when several processor exception requests are pending at once. For the chosen exception it produces the entry side effects: the new processor mode, the updated interrupt mask bits, the handler vector address, and a write strobe with the return address and status word to be stored in the banked link and saved-status registers. Instruction execution, the register file and the memory system are not part of this block. The core tells the controller when an instruction boundary allows an entry (`entry_ok`), and the controller answers one cycle later with a registered entry record.

The priority is fixed. A data abort outranks a fast interrupt, so that a bus fault is never lost. When both are pending and fast interrupts are unmasked, the controller enters the abort handler first. At the next entry opportunity it then enters the fast-interrupt handler, so a return from that handler resumes the abort handler. Undefined-instruction and software-interrupt requests share the lowest slot, because they come from different decodes of one instruction.

A processor reset request gets its own sequence. While the request is held, no entry is made, any pending chain is dropped, and the block drives idle fetches from word addresses that climb by four. When the request is released, a reset entry is made into supervisor mode at address zero with both masks set. The block also pulses flush strobes for the translation buffer, the cache and the write buffer, and presents the post-reset configuration levels.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Ordinary requests are arbitrated in this fixed order, highest first: data abort, fast interrupt, normal interrupt, prefetch abort, then undefined/software interrupt. The reset sequence of R10 and R11 overrides all of them. `ent_kind` encodes the winner as none=0, reset=1, data abort=2, fast interrupt=3, normal interrupt=4, prefetch abort=5, undefined=6, software interrupt=7.
- R2: A fast-interrupt request is ignored while `cur_psr[6]` (F) is 1, and a normal-interrupt request is ignored while `cur_psr[7]` (I) is 1. A masked request lets the next enabled request win.
- R3: Undefined and software-interrupt requests share the lowest slot and are never raised together. If only one is raised, that one is entered.
- R4: When a data abort wins while a fast interrupt is requested and F is 0, a fast-interrupt entry is made at the next cycle with `entry_ok`=1. This happens even if the request has since dropped, and it comes before any other non-reset request.
- R5: Entries other than the reset entry happen only in cycles with `entry_ok`=1. The record is registered and appears on the cycle after that edge, and `ent_vld` and `bank_wr` are single-cycle pulses.
- R6: `ent_mode` per kind: fast interrupt 5'b10001, normal interrupt 5'b10010, both aborts 5'b10111, undefined 5'b11011, software interrupt and reset 5'b10011.
- R7: `ent_vector` per kind: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R8: Every entry sets `ent_irq_mask`. `ent_fiq_mask` is set for fast-interrupt and reset entries. For every other entry it repeats the F bit of `cur_psr` from the entry cycle.
- R9: For each entry, `bank_lr` carries `cur_pc` and `bank_spsr` carries `cur_psr` as sampled in the entry cycle.
- R10: While `req_reset`=1, no entry is made and a pending chain is cancelled. `idle_fetch` is 1 from the cycle after the first held edge. `idle_addr` starts at `cur_pc` with its two low bits cleared and increases by 4 each cycle.
- R11: At the first edge with `req_reset`=0 after it was 1, a reset entry is made whatever `entry_ok` is: kind 1, mode 5'b10011, both masks set, vector 0x00, and `idle_fetch` returns to 0.
- R12: The reset entry pulses `flush_tlb`, `flush_cache` and `flush_wbuf` for one cycle, together with the entry record. The configuration outputs show translation, alignment checking, cache and write buffer all disabled, with 26-bit mode, early abort timing and little-endian order (`big_endian`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| entry_ok | input | 1 | Instruction boundary: an entry may be made this cycle |
| req_reset | input | 1 | Processor reset request (level) |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| cur_pc | input | 32 | Current program counter |
| cur_psr | input | 32 | Current status word; [4:0] mode, [6] F, [7] I |
| ent_vld | output | 1 | Entry record valid (one-cycle pulse) |
| ent_kind | output | 3 | Kind of exception entered |
| ent_mode | output | 5 | New mode field |
| ent_irq_mask | output | 1 | New I bit |
| ent_fiq_mask | output | 1 | New F bit |
| ent_vector | output | 32 | Handler fetch address |
| bank_wr | output | 1 | Write strobe for banked link and saved-status registers |
| bank_lr | output | 32 | Return address to store |
| bank_spsr | output | 32 | Status word to store |
| idle_fetch | output | 1 | Idle fetch cycle during reset hold |
| idle_addr | output | 32 | Idle fetch word address |
| flush_tlb | output | 1 | Translation buffer flush pulse |
| flush_cache | output | 1 | Cache flush pulse |
| flush_wbuf | output | 1 | Write buffer flush pulse |
| mmu_en | output | 1 | Address translation enable |
| align_en | output | 1 | Alignment check enable |
| cache_en | output | 1 | Cache enable |
| wbuf_en | output | 1 | Write buffer enable |
| addr26 | output | 1 | 26-bit address/data mode |
| early_abort | output | 1 | Early abort timing selected |
| big_endian | output | 1 | Big-endian order selected |

## Verification
The assertions check every cycle that a normal interrupt is never entered while I was set and that a prefetch abort never wins over a data abort. They also check that the stored return address and status match the entry cycle, that a pending chain produces a fast-interrupt entry at the next opportunity, that idle addresses step by four, and that flush pulses occur only with a reset entry. The bench's scenarios cover the full table of mode, mask and vector for every mix of pending requests and mask bits. They also cover chaining across cycles in which `entry_ok` is held low, a chain being cancelled by a reset, and the exact order of idle addresses and configuration levels across a reset hold and release.

// File: rtl/exc_entry_pkg.sv
// Shared types and lookup functions for the exception entry controller.
// Assumes a 5-bit mode field and vector offsets that fit in 8 bits.
package exc_entry_pkg;

    localparam int MODE_W = 5;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        EK_NONE  = 3'd0,
        EK_RESET = 3'd1,
        EK_DABT  = 3'd2,
        EK_FIQ   = 3'd3,
        EK_IRQ   = 3'd4,
        EK_PABT  = 3'd5,
        EK_UND   = 3'd6,
        EK_SWI   = 3'd7
    } exc_kind_e;

    // Mode field written on entry for each kind.
    function automatic logic [MODE_W-1:0] kind_mode(input exc_kind_e k);
        case (k)
            EK_FIQ:  return 5'b10001;
            EK_IRQ:  return 5'b10010;
            EK_DABT,
            EK_PABT: return 5'b10111;
            EK_UND:  return 5'b11011;
            default: return 5'b10011;
        endcase
    endfunction

    // Low byte of the handler address for each kind.
    function automatic logic [7:0] kind_vec(input exc_kind_e k);
        case (k)
            EK_UND:  return 8'h04;
            EK_SWI:  return 8'h08;
            EK_PABT: return 8'h0C;
            EK_DABT: return 8'h10;
            EK_IRQ:  return 8'h18;
            EK_FIQ:  return 8'h1C;
            default: return 8'h00;
        endcase
    endfunction

    // Kind served by each slot of the ordinary priority vector (0 = highest).
    function automatic exc_kind_e slot_kind(input int idx);
        case (idx)
            0:       return EK_DABT;
            1:       return EK_FIQ;
            2:       return EK_IRQ;
            3:       return EK_PABT;
            4:       return EK_UND;
            default: return EK_SWI;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
// Fixed-priority arbiter: picks one exception kind per cycle.
// Assumes the reset sequencer supplies hold/exit flags and the chain
// controller supplies the pending fast-interrupt chain flag.
module exc_prio_arb
    import exc_entry_pkg::*;
#(
    parameter int NSLOT = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      entry_ok,
    input  logic      rst_hold,
    input  logic      rst_exit,
    input  logic      chain_fiq,
    input  logic      req_dabt,
    input  logic      req_fiq,
    input  logic      req_irq,
    input  logic      req_pabt,
    input  logic      req_und,
    input  logic      req_swi,
    input  logic      fiq_ok,
    input  logic      irq_ok,
    output exc_kind_e sel,
    output logic      chain_set
);

    logic [NSLOT-1:0] cand;
    exc_kind_e        pick;

    // Build the masked request vector in priority order.
    always_comb begin
        cand    = '0;
        cand[0] = req_dabt;
        cand[1] = req_fiq & fiq_ok;
        cand[2] = req_irq & irq_ok;
        cand[3] = req_pabt;
        cand[4] = req_und;
        cand[5] = req_swi;
    end

    // Lowest index wins: scan downward so the last hit is the highest priority.
    always_comb begin
        pick = EK_NONE;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (cand[i]) pick = slot_kind(i);
        end
    end

    // Apply the overrides: reset hold, reset exit, boundary, chained entry.
    always_comb begin
        if (rst_hold)       sel = EK_NONE;
        else if (rst_exit)  sel = EK_RESET;
        else if (!entry_ok) sel = EK_NONE;
        else if (chain_fiq) sel = EK_FIQ;
        else                sel = pick;
    end

    // Arm a chain when the abort wins over an enabled fast interrupt.
    assign chain_set = (sel == EK_DABT) && req_fiq && fiq_ok;

    // R3
    und_swi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_und && req_swi));

endmodule

// File: rtl/exc_chain_ctl.sv
// Holds the pending fast-interrupt chain armed by a data-abort entry.
// Assumes the arbiter serves the chain first at the next opportunity.
module exc_chain_ctl
    import exc_entry_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rst_hold,
    input  logic      chain_set,
    input  exc_kind_e sel,
    output logic      chain_q
);

    // Set on abort-over-FIQ, cleared by the FIQ entry or by a reset hold.
    always_ff @(posedge clk) begin
        if (!rst_n)               chain_q <= 1'b0;
        else if (rst_hold)        chain_q <= 1'b0;
        else if (chain_set)       chain_q <= 1'b1;
        else if (sel == EK_FIQ)   chain_q <= 1'b0;
    end

    // R4
    chain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q && (sel == EK_FIQ) |=> !chain_q);

endmodule

// File: rtl/exc_reset_seq.sv
// Tracks the processor reset request: idle fetch addresses while held,
// an exit flag on release, flush pulses and post-reset configuration.
// Assumes req_reset is synchronous to clk.
module exc_reset_seq #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_reset,
    input  logic [AW-1:0] cur_pc,
    output logic          rst_hold,
    output logic          rst_exit,
    output logic          idle_fetch,
    output logic [AW-1:0] idle_addr,
    output logic          flush_tlb,
    output logic          flush_cache,
    output logic          flush_wbuf,
    output logic          mmu_en,
    output logic          align_en,
    output logic          cache_en,
    output logic          wbuf_en,
    output logic          addr26,
    output logic          early_abort,
    output logic          big_endian
);

    localparam int WSTEP = 4;

    logic rst_q;

    assign rst_hold = req_reset;
    assign rst_exit = rst_q & ~req_reset;

    // Remember the request level to find the release edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= req_reset;
    end

    // Idle fetch: load the aligned PC, then step one word per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_fetch <= 1'b0;
            idle_addr  <= '0;
        end else if (req_reset) begin
            idle_fetch <= 1'b1;
            if (!rst_q) idle_addr <= {cur_pc[AW-1:2], 2'b00};
            else        idle_addr <= idle_addr + AW'(WSTEP);
        end else begin
            idle_fetch <= 1'b0;
            if (rst_q) idle_addr <= '0;
        end
    end

    // One-cycle flush pulses on reset exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_tlb   <= 1'b0;
            flush_cache <= 1'b0;
            flush_wbuf  <= 1'b0;
        end else begin
            flush_tlb   <= rst_exit;
            flush_cache <= rst_exit;
            flush_wbuf  <= rst_exit;
        end
    end

    // Post-reset configuration levels, reloaded on every reset exit.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_exit) begin
            mmu_en      <= 1'b0;
            align_en    <= 1'b0;
            cache_en    <= 1'b0;
            wbuf_en     <= 1'b0;
            addr26      <= 1'b1;
            early_abort <= 1'b1;
            big_endian  <= 1'b0;
        end
    end

    // R10
    idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_fetch && $past(idle_fetch) |-> idle_addr == $past(idle_addr) + AW'(WSTEP));

    // R10
    idle_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_fetch |-> idle_addr[1:0] == 2'b00);

endmodule

// File: rtl/exc_entry_fmt.sv
// Registers the entry record: kind, mode, masks, vector and banked data.
// Assumes sel is EK_NONE in cycles where no entry may be made.
module exc_entry_fmt
    import exc_entry_pkg::*;
#(
    parameter int AW   = 32,
    parameter int PW   = 32,
    parameter int IBIT = 7,
    parameter int FBIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  exc_kind_e         sel,
    input  logic [AW-1:0]     cur_pc,
    input  logic [PW-1:0]     cur_psr,
    output logic              ent_vld,
    output logic [KIND_W-1:0] ent_kind,
    output logic [MODE_W-1:0] ent_mode,
    output logic              ent_irq_mask,
    output logic              ent_fiq_mask,
    output logic [AW-1:0]     ent_vector,
    output logic              bank_wr,
    output logic [AW-1:0]     bank_lr,
    output logic [PW-1:0]     bank_spsr
);

    logic take;
    logic f_next;

    assign take   = (sel != EK_NONE);
    assign f_next = (sel == EK_FIQ || sel == EK_RESET) ? 1'b1 : cur_psr[FBIT];

    // Valid and write strobe: one pulse per entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= 1'b0;
            bank_wr <= 1'b0;
        end else begin
            ent_vld <= take;
            bank_wr <= take;
        end
    end

    // Entry fields: loaded on an entry, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_kind     <= '0;
            ent_mode     <= '0;
            ent_irq_mask <= 1'b0;
            ent_fiq_mask <= 1'b0;
            ent_vector   <= '0;
            bank_lr      <= '0;
            bank_spsr    <= '0;
        end else if (take) begin
            ent_kind     <= sel;
            ent_mode     <= kind_mode(sel);
            ent_irq_mask <= 1'b1;
            ent_fiq_mask <= f_next;
            ent_vector   <= AW'(kind_vec(sel));
            bank_lr      <= cur_pc;
            bank_spsr    <= cur_psr;
        end
    end

    // R9
    bank_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |-> bank_lr == $past(cur_pc) && bank_spsr == $past(cur_psr));

    // R8
    f_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld && ent_kind != EK_FIQ && ent_kind != EK_RESET
        |-> ent_fiq_mask == $past(cur_psr[FBIT]));

    // R5
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld |-> bank_wr);

endmodule

// File: rtl/exc_entry_ctrl.sv
// Top of the exception entry controller: arbiter, chain flag, reset
// sequencer and entry record formatter. Assumes all requests are
// synchronous levels sampled at the rising clock edge.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int AW   = 32,
    parameter int PW   = 32,
    parameter int IBIT = 7,
    parameter int FBIT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          entry_ok,
    input  logic          req_reset,
    input  logic          req_dabt,
    input  logic          req_fiq,
    input  logic          req_irq,
    input  logic          req_pabt,
    input  logic          req_und,
    input  logic          req_swi,
    input  logic [AW-1:0] cur_pc,
    input  logic [PW-1:0] cur_psr,
    output logic          ent_vld,
    output logic [2:0]    ent_kind,
    output logic [4:0]    ent_mode,
    output logic          ent_irq_mask,
    output logic          ent_fiq_mask,
    output logic [AW-1:0] ent_vector,
    output logic          bank_wr,
    output logic [AW-1:0] bank_lr,
    output logic [PW-1:0] bank_spsr,
    output logic          idle_fetch,
    output logic [AW-1:0] idle_addr,
    output logic          flush_tlb,
    output logic          flush_cache,
    output logic          flush_wbuf,
    output logic          mmu_en,
    output logic          align_en,
    output logic          cache_en,
    output logic          wbuf_en,
    output logic          addr26,
    output logic          early_abort,
    output logic          big_endian
);

    exc_kind_e sel;
    logic      rst_hold;
    logic      rst_exit;
    logic      chain_q;
    logic      chain_set;
    logic      fiq_ok;
    logic      irq_ok;

    assign fiq_ok = ~cur_psr[FBIT];
    assign irq_ok = ~cur_psr[IBIT];

    exc_prio_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .entry_ok  (entry_ok),
        .rst_hold  (rst_hold),
        .rst_exit  (rst_exit),
        .chain_fiq (chain_q),
        .req_dabt  (req_dabt),
        .req_fiq   (req_fiq),
        .req_irq   (req_irq),
        .req_pabt  (req_pabt),
        .req_und   (req_und),
        .req_swi   (req_swi),
        .fiq_ok    (fiq_ok),
        .irq_ok    (irq_ok),
        .sel       (sel),
        .chain_set (chain_set)
    );

    exc_chain_ctl u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_hold  (rst_hold),
        .chain_set (chain_set),
        .sel       (sel),
        .chain_q   (chain_q)
    );

    exc_reset_seq #(.AW(AW)) u_rseq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_reset   (req_reset),
        .cur_pc      (cur_pc),
        .rst_hold    (rst_hold),
        .rst_exit    (rst_exit),
        .idle_fetch  (idle_fetch),
        .idle_addr   (idle_addr),
        .flush_tlb   (flush_tlb),
        .flush_cache (flush_cache),
        .flush_wbuf  (flush_wbuf),
        .mmu_en      (mmu_en),
        .align_en    (align_en),
        .cache_en    (cache_en),
        .wbuf_en     (wbuf_en),
        .addr26      (addr26),
        .early_abort (early_abort),
        .big_endian  (big_endian)
    );

    exc_entry_fmt #(.AW(AW), .PW(PW), .IBIT(IBIT), .FBIT(FBIT)) u_fmt (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel),
        .cur_pc       (cur_pc),
        .cur_psr      (cur_psr),
        .ent_vld      (ent_vld),
        .ent_kind     (ent_kind),
        .ent_mode     (ent_mode),
        .ent_irq_mask (ent_irq_mask),
        .ent_fiq_mask (ent_fiq_mask),
        .ent_vector   (ent_vector),
        .bank_wr      (bank_wr),
        .bank_lr      (bank_lr),
        .bank_spsr    (bank_spsr)
    );

    // R2
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld && ent_kind == 3'd4 |-> !$past(cur_psr[IBIT]));

    // R1
    pabt_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld && ent_kind == 3'd5 |-> !$past(req_dabt));

    // R4
    chain_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q && entry_ok && !req_reset && !rst_exit |=> ent_vld && ent_kind == 3'd3);

    // R5
    boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld && ent_kind != 3'd1 |-> $past(entry_ok));

    // R12
    flush_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_tlb |-> ent_vld && ent_kind == 3'd1);

endmodule

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_ok = 1'b0;
    logic        req_reset = 1'b0;
    logic        req_dabt = 1'b0, req_fiq = 1'b0, req_irq = 1'b0;
    logic        req_pabt = 1'b0, req_und = 1'b0, req_swi = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_psr = '0;
    logic        ent_vld, ent_irq_mask, ent_fiq_mask, bank_wr, idle_fetch;
    logic [2:0]  ent_kind;
    logic [4:0]  ent_mode;
    logic [31:0] ent_vector, bank_lr, bank_spsr, idle_addr;
    logic        flush_tlb, flush_cache, flush_wbuf;
    logic        mmu_en, align_en, cache_en, wbuf_en, addr26, early_abort, big_endian;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .entry_ok(entry_ok), .req_reset(req_reset),
        .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq),
        .req_pabt(req_pabt), .req_und(req_und), .req_swi(req_swi),
        .cur_pc(cur_pc), .cur_psr(cur_psr),
        .ent_vld(ent_vld), .ent_kind(ent_kind), .ent_mode(ent_mode),
        .ent_irq_mask(ent_irq_mask), .ent_fiq_mask(ent_fiq_mask),
        .ent_vector(ent_vector), .bank_wr(bank_wr), .bank_lr(bank_lr),
        .bank_spsr(bank_spsr), .idle_fetch(idle_fetch), .idle_addr(idle_addr),
        .flush_tlb(flush_tlb), .flush_cache(flush_cache), .flush_wbuf(flush_wbuf),
        .mmu_en(mmu_en), .align_en(align_en), .cache_en(cache_en), .wbuf_en(wbuf_en),
        .addr26(addr26), .early_abort(early_abort), .big_endian(big_endian)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_kind(input bit d, input bit f, input bit i, input bit p,
                                    input bit u, input bit s, input bit ib, input bit fb);
        if (d)             return 2;
        if (f && !fb)      return 3;
        if (i && !ib)      return 4;
        if (p)             return 5;
        if (u)             return 6;
        if (s)             return 7;
        return 0;
    endfunction

    function automatic logic [4:0] exp_mode(input int k);
        case (k)
            3: return 5'b10001;
            4: return 5'b10010;
            2, 5: return 5'b10111;
            6: return 5'b11011;
            default: return 5'b10011;
        endcase
    endfunction

    function automatic logic [31:0] exp_vec(input int k);
        case (k)
            2: return 32'h10;
            3: return 32'h1C;
            4: return 32'h18;
            5: return 32'h0C;
            6: return 32'h04;
            7: return 32'h08;
            default: return 32'h00;
        endcase
    endfunction

    task automatic clear_reqs();
        req_dabt = 0; req_fiq = 0; req_irq = 0; req_pabt = 0; req_und = 0; req_swi = 0;
    endtask

    // Advance one edge and land on the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_entry(input string req, input int k, input bit fb,
                               input logic [31:0] pc, input logic [31:0] psr);
        chk(req, "vld", ent_vld, 1);
        chk(req, "kind", ent_kind, k);
        chk("R6", "mode", ent_mode, exp_mode(k));
        chk("R7", "vector", ent_vector, exp_vec(k));
        chk("R8", "imask", ent_irq_mask, 1);
        chk("R8", "fmask", ent_fiq_mask, (k == 3 || k == 1) ? 1 : fb);
        chk("R9", "bank_wr", bank_wr, 1);
        chk("R9", "lr", bank_lr, pc);
        chk("R9", "spsr", bank_spsr, psr);
    endtask

    task automatic t_reset_state();
        chk("R5", "vld after reset", ent_vld, 0);
        chk("R10", "idle after reset", idle_fetch, 0);
        chk("R12", "flush after reset", flush_tlb | flush_cache | flush_wbuf, 0);
    endtask

    // R1 R2 R3 R4: every mix of requests and mask bits.
    task automatic t_all_combos();
        for (int c = 0; c < 192; c++) begin
            bit d, f, i, p, u, s, ib, fb;
            int us, msk, k;
            logic [31:0] pc, psr;
            d = c[0]; f = c[1]; i = c[2]; p = c[3];
            us = (c >> 4) % 3; msk = (c >> 4) / 3;
            u = (us == 1); s = (us == 2);
            ib = msk[1]; fb = msk[0];
            pc = 32'h1000 + c * 4;
            psr = {24'h0, ib, fb, 1'b0, 5'b10000};
            req_dabt = d; req_fiq = f; req_irq = i; req_pabt = p; req_und = u; req_swi = s;
            cur_pc = pc; cur_psr = psr; entry_ok = 1;
            step();
            k = exp_kind(d, f, i, p, u, s, ib, fb);
            if (k == 0) chk("R2", "no entry", ent_vld, 0);
            else        check_entry("R1", k, fb, pc, psr);
            clear_reqs();
            if (k == 2 && f && !fb) begin
                cur_pc = 32'h3000; cur_psr = 32'h0000_0097;
                req_pabt = 1;
                step();
                check_entry("R4", 3, 0, 32'h3000, 32'h0000_0097);
                clear_reqs();
            end
            entry_ok = 0;
            step();
            chk("R5", "pulse ends", ent_vld, 0);
        end
    endtask

    // R5: requests wait for the boundary signal.
    task automatic t_boundary();
        cur_psr = 32'h0000_0010; cur_pc = 32'h4000;
        req_irq = 1; entry_ok = 0;
        step();
        chk("R5", "held off 1", ent_vld, 0);
        step();
        chk("R5", "held off 2", ent_vld, 0);
        entry_ok = 1;
        step();
        check_entry("R5", 4, 0, 32'h4000, 32'h0000_0010);
        clear_reqs(); entry_ok = 0;
        step();
    endtask

    // R4: chain survives cycles without a boundary, beats a new abort.
    task automatic t_chain_wait();
        cur_psr = 32'h0000_0010; cur_pc = 32'h5000;
        req_dabt = 1; req_fiq = 1; entry_ok = 1;
        step();
        check_entry("R4", 2, 0, 32'h5000, 32'h0000_0010);
        clear_reqs(); entry_ok = 0;
        step();
        chk("R4", "no entry while waiting", ent_vld, 0);
        step();
        req_dabt = 1; entry_ok = 1; cur_pc = 32'h5010; cur_psr = 32'h0000_0097;
        step();
        check_entry("R4", 3, 0, 32'h5010, 32'h0000_0097);
        clear_reqs(); entry_ok = 0;
        step();
    endtask

    // R10 R11 R12: hold, idle fetch, release, chain cancel.
    task automatic t_reset_seq();
        cur_psr = 32'h0000_0010; cur_pc = 32'h6000;
        req_dabt = 1; req_fiq = 1; entry_ok = 1;
        step();
        check_entry("R4", 2, 0, 32'h6000, 32'h0000_0010);
        clear_reqs();
        cur_pc = 32'h2002; req_reset = 1; req_irq = 1;
        step();
        chk("R10", "idle on", idle_fetch, 1);
        chk("R10", "idle addr0", idle_addr, 32'h2000);
        chk("R10", "no entry in hold", ent_vld, 0);
        step();
        chk("R10", "idle addr1", idle_addr, 32'h2004);
        step();
        chk("R10", "idle addr2", idle_addr, 32'h2008);
        chk("R10", "no entry in hold 2", ent_vld, 0);
        clear_reqs(); req_reset = 0; entry_ok = 0; cur_pc = 32'h2010;
        step();
        check_entry("R11", 1, 1, 32'h2010, 32'h0000_0010);
        chk("R11", "idle off", idle_fetch, 0);
        chk("R12", "flush tlb", flush_tlb, 1);
        chk("R12", "flush cache", flush_cache, 1);
        chk("R12", "flush wbuf", flush_wbuf, 1);
        chk("R12", "cfg", {mmu_en, align_en, cache_en, wbuf_en, addr26, early_abort, big_endian},
            7'b0000110);
        entry_ok = 1;
        step();
        chk("R10", "chain cancelled", ent_vld, 0);
        chk("R12", "flush pulse ends", flush_tlb | flush_cache | flush_wbuf, 0);
        entry_ok = 0;
        step();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        step();
        t_reset_state();
        t_all_combos();
        t_boundary();
        t_chain_wait();
        t_reset_seq();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule